// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block sits on the host side of a command-driven parallel flash part. It writes a run of bytes, from a start address to an end address inclusive, into the flash. It uses the pulse-and-verify method. For each byte it writes a program-setup command, then a write that carries the target address and data. It lets the cell program for a fixed time, then writes a margin-verify command, waits a settle time, reads the byte back and compares it with the data it intended to write. On a mismatch it applies another pulse to the same byte, up to a hard per-byte limit. On a match it moves to the next address. The data for each byte comes from a request/valid handshake with a data source. All flash traffic goes through a single-outstanding bus-master port that holds each request until it is acknowledged.

When the run ends, by success on the last byte or by a byte that exhausts its pulses, the sequencer writes the read command. It then drops its request for the high programming supply and gives a one-cycle done strobe with a pass flag. On failure it also reports the failing address. The wait times are parameters counted in clock cycles.

The state machine has ten states:

| State | Action | Transitions |
|---|---|---|
| IDLE | Waits for work. | On start, goes to FETCH. |
| FETCH | Requests the next data byte. | On valid, goes to SETUP. |
| SETUP | Writes 40h. | On acknowledge, goes to LATCH. |
| LATCH | Writes the address and data. | On acknowledge, goes to PGM_WAIT. |
| PGM_WAIT | Counts the program time. | When expired, goes to VFY_CMD. |
| VFY_CMD | Writes C0h. | On acknowledge, goes to VFY_WAIT. |
| VFY_WAIT | Counts the settle time. | When expired, goes to VFY_READ. |
| VFY_READ | Reads the byte back and compares it. | See below. |
| EXIT | Writes 00h. | On acknowledge, goes to DONE. |
| DONE | Gives the strobe. | Always goes to IDLE. |

VFY_READ has four outcomes when the read is acknowledged:
- match on the last byte: EXIT with a pass;
- match on another byte: the address steps and the state goes to FETCH;
- mismatch with pulses left: SETUP;
- mismatch at the limit: EXIT with a fail.

Top module: `fps_ctrl`

## Requirements
- R1: After reset the block is idle: busy, done, pass, vpp_req, data_req and bus_req are all 0.
- R2: A start while idle latches first_addr and last_addr. In the next cycle busy, vpp_req and data_req are 1 and no bus request is raised. data_req stays high until data_vld is seen, and data_in is captured in that cycle.
- R3: A pulse is a bus write (bus_wr=1) of 40h followed by a bus write of the captured data. Both carry the current byte address on bus_addr.
- R4: At least PGM_CYC cycles pass between the completion of the data write and the completion of the following C0h write. At least VFY_CYC cycles pass between the completion of the C0h write and the completion of the verify read (bus_wr=0, same address).
- R5: On a verify read whose bus_rdata equals the captured data, the block moves to address+1 with a fresh data request, unless that byte is the last. On a mismatch, another pulse is applied to the same address.
- R6: A byte gets at most PULSE_MAX pulses (default 25). A mismatch on the PULSE_MAX-th verify ends the run as a failure, and no later address is touched. The pulse count restarts at zero for each byte, so a byte that matches on its PULSE_MAX-th verify passes.
- R7: Every run ends with a bus write of 00h, then a one-cycle done pulse. vpp_req is 0 in the done cycle. pass is valid with done (1 for success) and busy returns to 0 after done.
- R8: With done and pass=0, fail_addr holds the address of the byte that exhausted its pulses.
- R9: A start while busy is ignored, as are changes to first_addr and last_addr: the bus sequence continues unchanged.
- R10: A bus request holds bus_req, bus_wr, bus_addr and bus_wdata stable until the cycle in which bus_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| first_addr | input | AW | First byte address of the run |
| last_addr | input | AW | Last byte address of the run (inclusive) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Run result, valid with done |
| fail_addr | output | AW | Failing address when done and not pass, else 0 |
| vpp_req | output | 1 | Request for the high programming supply |
| data_req | output | 1 | Request for the next data byte |
| data_vld | input | 1 | Data source answer to data_req |
| data_in | input | DW | Data byte for the current address |
| bus_req | output | 1 | Bus transfer request |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Flash byte address |
| bus_wdata | output | DW | Write data or command code |
| bus_ack | input | 1 | Transfer complete |
| bus_rdata | input | DW | Read data, valid with bus_ack on reads |

## Verification
The assertions check the following on every cycle:
- the bus request is held stable until it is acknowledged;
- done lasts one cycle and the supply request is already low in that cycle;
- data is requested only while the bus is quiet;
- an active run never falls straight back to idle;
- the pulse counter never increments past its limit;
- the address never steps past the end.

Only the bench scenarios can show the per-byte order of command codes and addresses, the minimum gaps of the two waits, and the retry counts. The same applies to the inclusive pulse limit, the restart of the counter for each byte, the reported failing address, and the fact that a second start leaves an active run untouched.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_LATCH,
        ST_PGM_WAIT,
        ST_VFY_CMD,
        ST_VFY_WAIT,
        ST_VFY_READ,
        ST_EXIT,
        ST_DONE
    } fps_state_t;

    localparam logic [7:0] CMD_PGM_SETUP  = 8'h40;
    localparam logic [7:0] CMD_PGM_VERIFY = 8'hC0;
    localparam logic [7:0] CMD_READ_ARRAY = 8'h00;

endpackage

// File: rtl/fps_wait_timer.sv
module fps_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fps_pulse_ctr.sv
module fps_pulse_ctr #(
    parameter int LIMIT = 25,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_limit
);
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count_q <= '0;
        else if (inc)
            count_q <= count_q + 1'b1;
    end

    assign at_limit = (count_q == CW'(LIMIT));

    // R6: a new pulse is only granted while the byte still has pulses left
    assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit);

endmodule

// File: rtl/fps_addr_walk.sv
module fps_addr_walk #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] last,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            last_q <= '0;
        end else if (load) begin
            addr_q <= first;
            last_q <= last;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == last_q);

    // R5: the walk never advances beyond the end of the run
    assert_no_step_past_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !at_last);

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int AW        = 18,
    parameter int DW        = 8,
    parameter int PGM_CYC   = 1000,
    parameter int VFY_CYC   = 600,
    parameter int PULSE_MAX = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [AW-1:0] fail_addr,
    output logic          vpp_req,
    output logic          data_req,
    input  logic          data_vld,
    input  logic [DW-1:0] data_in,
    output logic          bus_req,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);
    localparam int TMR_MAX = (PGM_CYC > VFY_CYC) ? PGM_CYC : VFY_CYC;
    localparam int TW      = $clog2(TMR_MAX + 1);

    fps_state_t st_q, st_nxt;

    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          pc_clr, pc_inc, pc_at_limit;
    logic          aw_load, aw_step, aw_at_last;
    logic [AW-1:0] cur_addr;
    logic          byte_cap, ok_set, ok_clr, vpp_set, vpp_clr;
    logic [DW-1:0] byte_q;
    logic          ok_q, vpp_q;
    logic          match;

    fps_wait_timer #(.CNT_W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    fps_pulse_ctr #(.LIMIT(PULSE_MAX)) u_pulses (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (pc_clr),
        .inc      (pc_inc),
        .at_limit (pc_at_limit)
    );

    fps_addr_walk #(.AW(AW)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (aw_load),
        .first   (first_addr),
        .last    (last_addr),
        .step    (aw_step),
        .addr    (cur_addr),
        .at_last (aw_at_last)
    );

    assign match = (bus_rdata == byte_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_nxt;
    end

    // next state and outputs
    always_comb begin
        st_nxt    = st_q;
        data_req  = 1'b0;
        bus_req   = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        done      = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        pc_clr    = 1'b0;
        pc_inc    = 1'b0;
        aw_load   = 1'b0;
        aw_step   = 1'b0;
        byte_cap  = 1'b0;
        ok_set    = 1'b0;
        ok_clr    = 1'b0;
        vpp_set   = 1'b0;
        vpp_clr   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    aw_load = 1'b1;
                    ok_clr  = 1'b1;
                    vpp_set = 1'b1;
                    st_nxt  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                data_req = 1'b1;
                if (data_vld) begin
                    byte_cap = 1'b1;
                    pc_clr   = 1'b1;
                    st_nxt   = ST_SETUP;
                end
            end
            ST_SETUP: begin
                bus_req   = 1'b1;
                bus_wr    = 1'b1;
                bus_wdata = DW'(CMD_PGM_SETUP);
                if (bus_ack) st_nxt = ST_LATCH;
            end
            ST_LATCH: begin
                bus_req   = 1'b1;
                bus_wr    = 1'b1;
                bus_wdata = byte_q;
                if (bus_ack) begin
                    pc_inc   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PGM_CYC);
                    st_nxt   = ST_PGM_WAIT;
                end
            end
            ST_PGM_WAIT: begin
                if (tmr_exp) st_nxt = ST_VFY_CMD;
            end
            ST_VFY_CMD: begin
                bus_req   = 1'b1;
                bus_wr    = 1'b1;
                bus_wdata = DW'(CMD_PGM_VERIFY);
                if (bus_ack) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(VFY_CYC);
                    st_nxt   = ST_VFY_WAIT;
                end
            end
            ST_VFY_WAIT: begin
                if (tmr_exp) st_nxt = ST_VFY_READ;
            end
            ST_VFY_READ: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    if (match) begin
                        if (aw_at_last) begin
                            ok_set = 1'b1;
                            st_nxt = ST_EXIT;
                        end else begin
                            aw_step = 1'b1;
                            st_nxt  = ST_FETCH;
                        end
                    end else if (pc_at_limit) begin
                        st_nxt = ST_EXIT;
                    end else begin
                        st_nxt = ST_SETUP;
                    end
                end
            end
            ST_EXIT: begin
                bus_req   = 1'b1;
                bus_wr    = 1'b1;
                bus_wdata = DW'(CMD_READ_ARRAY);
                if (bus_ack) begin
                    vpp_clr = 1'b1;
                    st_nxt  = ST_DONE;
                end
            end
            ST_DONE: begin
                done   = 1'b1;
                st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            ok_q   <= 1'b0;
            vpp_q  <= 1'b0;
        end else begin
            if (byte_cap) byte_q <= data_in;
            if (ok_clr)
                ok_q <= 1'b0;
            else if (ok_set)
                ok_q <= 1'b1;
            if (vpp_set)
                vpp_q <= 1'b1;
            else if (vpp_clr)
                vpp_q <= 1'b0;
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign pass      = ok_q;
    assign vpp_req   = vpp_q;
    assign bus_addr  = cur_addr;
    assign fail_addr = (done && !ok_q) ? cur_addr : '0;

    // R10: an outstanding request is held unchanged until acknowledged
    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_wr)
                                   && $stable(bus_addr) && $stable(bus_wdata)));

    // R7: the done strobe lasts exactly one cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the supply request is already released when done is shown
    assert_supply_low_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !vpp_req);

    // R2: data is fetched only during a run and with the bus idle
    assert_fetch_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> (busy && !bus_req && vpp_req));

    // R9: an active run never returns to idle without passing through done
    assert_run_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/test_fps_ctrl.sv
module test_fps_ctrl;
    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int PGM = 20;
    localparam int VFY = 10;
    localparam int LIM = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] first_addr = '0;
    logic [AW-1:0] last_addr = '0;
    logic          busy, done, pass, vpp_req, data_req;
    logic [AW-1:0] fail_addr;
    logic          data_vld = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          bus_req, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    always #5 clk = ~clk;

    fps_ctrl #(.AW(AW), .DW(DW), .PGM_CYC(PGM), .VFY_CYC(VFY), .PULSE_MAX(LIM)) i_fps_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
        .last_addr(last_addr), .busy(busy), .done(done), .pass(pass),
        .fail_addr(fail_addr), .vpp_req(vpp_req), .data_req(data_req),
        .data_vld(data_vld), .data_in(data_in), .bus_req(bus_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            kind; // 0 setup, 1 data, 2 verify cmd, 3 read, 4 exit
    } txn_t;

    txn_t          exp_q[$];
    int            need [64];
    int            seen [64];
    logic [DW-1:0] mem  [64];
    int            n_chk = 0;
    int            n_bad = 0;
    longint        cyc = 0;
    longint        t_data = 0;
    longint        t_vcmd = 0;
    int            src_addr = 0;
    bit            armed = 0;

    function automatic logic [DW-1:0] pat(int a);
        return 8'h40 | 8'(a & 63);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // flash and data source model
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack  <= 1'b0;
            data_vld <= 1'b0;
        end else begin
            bus_ack <= bus_req && !bus_ack;
            if (bus_req && !bus_ack && !bus_wr)
                bus_rdata <= mem[bus_addr[5:0]];
            if (bus_req && bus_ack && bus_wr) begin
                if (armed) begin
                    seen[bus_addr[5:0]]++;
                    if (seen[bus_addr[5:0]] >= need[bus_addr[5:0]])
                        mem[bus_addr[5:0]] = bus_wdata;
                    armed = 0;
                end else if (bus_wdata == 8'h40) begin
                    armed = 1;
                end
            end
            data_vld <= data_req && !data_vld;
            if (data_req && !data_vld) begin
                data_in <= pat(src_addr);
                src_addr++;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n && bus_req && bus_ack) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected bus transfer", longint'(bus_addr), 0);
            end else begin
                txn_t e;
                e = exp_q.pop_front();
                chk(bus_wr == e.wr, "R3 bus direction", bus_wr, e.wr);
                chk(bus_addr == e.a, "R5 bus address", bus_addr, e.a);
                if (e.wr)
                    chk(bus_wdata == e.d, "R3 write data or command", bus_wdata, e.d);
                if (e.kind == 1) t_data = cyc;
                if (e.kind == 2) begin
                    chk(cyc - t_data >= PGM, "R4 program wait", cyc - t_data, PGM);
                    t_vcmd = cyc;
                end
                if (e.kind == 3)
                    chk(cyc - t_vcmd >= VFY, "R4 verify wait", cyc - t_vcmd, VFY);
            end
        end
    end

    task automatic push(logic wr, int a, logic [DW-1:0] d, int kind);
        txn_t t;
        t.wr = wr; t.a = AW'(a); t.d = d; t.kind = kind;
        exp_q.push_back(t);
    endtask

    task automatic run_job(int first, int last, bit poke_busy);
        bit fail = 0;
        int fa = 0;
        for (int a = first; a <= last; a++) begin
            mem[a] = 8'hFF;
            seen[a] = 0;
        end
        for (int a = first; a <= last && !fail; a++) begin
            int p = 0;
            do begin
                p++;
                push(1, a, 8'h40, 0);
                push(1, a, pat(a), 1);
                push(1, a, 8'hC0, 2);
                push(0, a, 8'h00, 3);
            end while (p < need[a] && p < LIM);
            if (need[a] > LIM) begin
                fail = 1;
                fa = a;
            end
        end
        push(1, fail ? fa : last, 8'h00, 4);
        src_addr = first;
        @(negedge clk);
        first_addr = AW'(first);
        last_addr  = AW'(last);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && vpp_req && data_req && !bus_req, "R2 run begins with data fetch",
            {busy, vpp_req, data_req, bus_req}, 4'b1110);
        if (poke_busy) begin
            repeat (30) @(negedge clk);
            first_addr = AW'(50);
            last_addr  = AW'(60);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R9 start while busy keeps run", busy, 1);
        end
        begin
            int guard = 0;
            while (!done && guard < 20000) begin
                @(negedge clk);
                guard++;
            end
        end
        chk(done, "R7 done reached", done, 1);
        chk(pass == !fail, "R7 pass result", pass, !fail);
        chk(fail_addr == (fail ? AW'(fa) : '0), "R8 failing address", fail_addr, fail ? fa : 0);
        chk(!vpp_req, "R7 supply released at done", vpp_req, 0);
        chk(exp_q.size() == 0, "R6 all expected transfers seen", exp_q.size(), 0);
        @(negedge clk);
        chk(!done && !busy, "R7 done is one cycle", {done, busy}, 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            need[i] = 1;
            seen[i] = 0;
            mem[i]  = 8'hFF;
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pass && !vpp_req && !data_req && !bus_req, "R1 reset state",
            {busy, done, pass, vpp_req, data_req, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 multi-byte run with retries, R9 start during the run
        need[4] = 1; need[5] = 3; need[6] = 1; need[7] = 2;
        run_job(4, 7, 1);

        // R5 single byte run, first equals last
        need[10] = 1;
        run_job(10, 10, 0);

        // R6 R8 byte that never programs, later byte untouched
        need[20] = 1; need[21] = 30; need[22] = 1;
        run_job(20, 22, 0);
        chk(mem[22] == 8'hFF, "R6 no later address programmed", mem[22], 8'hFF);

        // R6 limit inclusive and counter restarts for each byte
        need[30] = LIM; need[31] = LIM;
        run_job(30, 31, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule